// File: doc/BRIEF.md
# EEPROM Word Address Pointer

This block keeps the byte address that a serial EEPROM uses for its next access, and moves that address forward as bytes go by. A write sequence that carries an address loads it in full. Each byte written moves the pointer forward inside its 128-byte page. The upper address bits do not change, so once the last byte of the page has been written the pointer returns to the first byte of the same page. Each byte read moves the pointer forward across the whole array, and after the top address it goes back to address zero.

The pointer keeps its value from one transaction to the next, and start or stop conditions do not clear it. After any access it therefore holds the last address touched plus one, and the next current-address read begins there. Only a synchronous reset clears it. The serial protocol, the storage array and the write timing belong to other blocks.

Every cycle an operation decoder picks one of four named operations: `OP_HOLD`, `OP_LOAD`, `OP_WR_STEP` or `OP_RD_STEP`. Two step units compute the in-page and the full-array successor, and a single register takes the value that the chosen operation names. The decoder has no stored state. The only transitions are those of the pointer register: it is reset to zero, it is loaded, or it is stepped.

Top module: `word_addr_pointer`

## Requirements
- R1: While `rst` is high at a clock edge, `addr` is 0x0000 after that edge, whatever the other inputs are.
- R2: With `load` high at an edge, `addr` equals `load_addr` after that edge.
- R3: A write step (`wr_step` high, `load` low) adds one to `addr[6:0]` and leaves `addr[15:7]` unchanged.
- R4: A write step taken when `addr[6:0]` is 0x7F sets `addr[6:0]` to 0x00 and keeps the page bits `addr[15:7]`. For example, 0x127F becomes 0x1200.
- R5: A read step (`rd_step` high, `load` and `wr_step` low) adds one to the full 16-bit address, carrying across page boundaries. For example, 0x007F becomes 0x0080.
- R6: A read step taken at 0xFFFF gives 0x0000.
- R7: With `load`, `wr_step` and `rd_step` all low, `addr` keeps its value for any number of cycles.
- R8: When `load` is high in the same cycle as either step strobe, the load is taken and the step is ignored.
- R9: When `wr_step` and `rd_step` are both high and `load` is low, the write step rule (R3, R4) applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load `load_addr` into the pointer |
| load_addr | input | 16 | Full address to load |
| wr_step | input | 1 | Advance within the current page after a byte is written |
| rd_step | input | 1 | Advance across the whole array after a byte is read |
| addr | output | 16 | Current pointer value |

## Verification
The bench goes after the page edge. A write step at low bits 0x7F that let the carry reach bit 7 would move the pointer into the next page instead of back to the start of its own page. A read step at 0x007F checks the opposite case: a read that wrapped within the page would return to 0x0000 instead of reaching 0x0080. The step at 0xFFFF checks that a read step wraps the full array to zero. Cycles in which several strobes are raised together check the priority order, where a wrong order would lose the loaded address or apply the read rule to a write.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_PAGE_W = 7;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_LOAD    = 2'd1,
        OP_WR_STEP = 2'd2,
        OP_RD_STEP = 2'd3
    } ptr_op_e;

endpackage

// File: rtl/ptr_op_decode.sv
module ptr_op_decode
    import addr_ptr_pkg::*;
(
    input  logic    load,
    input  logic    wr_step,
    input  logic    rd_step,
    output ptr_op_e op
);

    // Priority: load, then write step, then read step.
    always_comb begin
        if (load) begin
            op = OP_LOAD;
        end else if (wr_step) begin
            op = OP_WR_STEP;
        end else if (rd_step) begin
            op = OP_RD_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ptr_page_step.sv
module ptr_page_step #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    localparam int unsigned ROW_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] offset_inc;

    // Only the in-page offset counts; the carry out of it is dropped.
    assign offset_inc = cur[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};

    generate
        if (ROW_W > 0) begin : g_row
            assign nxt = {cur[ADDR_W-1:PAGE_W], offset_inc};
        end else begin : g_flat
            assign nxt = offset_inc;
        end
    endgenerate

endmodule

// File: rtl/ptr_array_step.sv
module ptr_array_step #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    // Modulo 2**ADDR_W: the top address wraps to zero.
    assign nxt = cur + {{(ADDR_W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/word_addr_pointer.sv
module word_addr_pointer
    import addr_ptr_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] addr
);

    ptr_op_e           op;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;
    logic [ADDR_W-1:0] page_nxt;
    logic [ADDR_W-1:0] array_nxt;

    ptr_op_decode u_decode (
        .load    (load),
        .wr_step (wr_step),
        .rd_step (rd_step),
        .op      (op)
    );

    ptr_page_step #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_page_step (
        .cur (ptr_q),
        .nxt (page_nxt)
    );

    ptr_array_step #(
        .ADDR_W (ADDR_W)
    ) u_array_step (
        .cur (ptr_q),
        .nxt (array_nxt)
    );

    always_comb begin
        unique case (op)
            OP_LOAD:    ptr_d = load_addr;
            OP_WR_STEP: ptr_d = page_nxt;
            OP_RD_STEP: ptr_d = array_nxt;
            default:    ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign addr = ptr_q;

endmodule

// File: rtl/word_addr_pointer_chk.sv
module word_addr_pointer_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [ADDR_W-1:0] load_addr,
    input logic              wr_step,
    input logic              rd_step,
    input logic [ADDR_W-1:0] addr
);

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            reset_zero_chk: assert (addr == '0);
        end
    end

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> addr == $past(load_addr));

    // R3
    wr_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_step) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

    // R4
    wr_page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_step && (&addr[PAGE_W-1:0])) |=> addr[PAGE_W-1:0] == '0);

    // R5
    rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_step && rd_step) |=> addr == $past(addr) + 1'b1);

    // R6
    rd_array_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_step && rd_step && (&addr)) |=> addr == '0);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_step && !rd_step) |=> $stable(addr));

endmodule

bind word_addr_pointer word_addr_pointer_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_addr (load_addr),
    .wr_step   (wr_step),
    .rd_step   (rd_step),
    .addr      (addr)
);

// File: tb/tb_word_addr_pointer.sv
module tb_word_addr_pointer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_addr = '0;
    logic        wr_step = 1'b0;
    logic        rd_step = 1'b0;
    logic [15:0] addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_addr_pointer dut (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (load_addr),
        .wr_step   (wr_step),
        .rd_step   (rd_step),
        .addr      (addr)
    );

    function automatic logic [15:0] model_next(input logic [15:0] cur, input logic r,
                                               input logic l, input logic [15:0] la,
                                               input logic w, input logic rd);
        if (r)       return 16'h0000;
        if (l)       return la;
        if (w)       return {cur[15:7], 7'((cur[6:0] + 7'd1))};
        if (rd)      return 16'(cur + 16'd1);
        return cur;
    endfunction

    function automatic string req_of(input logic r, input logic l, input logic w,
                                     input logic rd, input logic [15:0] cur);
        if (r)                   return "R1 reset";
        if (l && (w || rd))      return "R8 load priority";
        if (l)                   return "R2 load";
        if (w && rd)             return "R9 write over read";
        if (w && cur[6:0] == 7'h7f) return "R4 page wrap";
        if (w)                   return "R3 write step";
        if (rd && cur == 16'hffff) return "R6 array wrap";
        if (rd)                  return "R5 read step";
        return "R7 hold";
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (addr !== exp) begin
            n_fail++;
            $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
        end
    endtask

    // Called at a falling edge; applies inputs for one rising edge and checks at the next falling edge.
    task automatic cyc(input logic r, input logic l, input logic [15:0] la,
                       input logic w, input logic rd);
        string req;
        req = req_of(r, l, w, rd, exp_addr);
        rst = r; load = l; load_addr = la; wr_step = w; rd_step = rd;
        exp_addr = model_next(exp_addr, r, l, la, w, rd);
        @(negedge clk);
        check(req, exp_addr);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset with other strobes active
        cyc(1'b1, 1'b1, 16'hbeef, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        // R7: idle after reset
        cyc(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h5555, 1'b0, 1'b0);
        // R2 then R3
        cyc(1'b0, 1'b1, 16'h1234, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
        // R4: 0x127F -> 0x1200
        cyc(1'b0, 1'b1, 16'h127f, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
        // R4 on the top page: 0xFFFF -> 0xFF80
        cyc(1'b0, 1'b1, 16'hffff, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
        // R5: read crosses the page, 0x007F -> 0x0080
        cyc(1'b0, 1'b1, 16'h007f, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);
        // R6: 0xFFFF -> 0x0000
        cyc(1'b0, 1'b1, 16'hffff, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b0, 1'b1);
        // R8: load beats both steps
        cyc(1'b0, 1'b1, 16'h0aff, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 16'h3c7f, 1'b0, 1'b1);
        // R9: both steps at a page end stay in the page
        cyc(1'b0, 1'b0, 16'h0000, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 16'h0000, 1'b1, 1'b1);
        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [15:0] la;
            logic [3:0]  sel;
            logic        r;
            logic        l;
            logic        w;
            logic        rd;
            sel = 4'($urandom_range(0, 15));
            case ($urandom_range(0, 2))
                0: la = {9'($urandom), 7'(7'h7c + 7'($urandom_range(0, 3)))};
                1: la = 16'(16'hfffc + 16'($urandom_range(0, 3)));
                default: la = 16'($urandom);
            endcase
            r  = ($urandom_range(0, 99) == 0);
            l  = (sel == 4'd0);
            w  = (sel[1:0] == 2'd1) || (sel == 4'd15);
            rd = (sel[1:0] == 2'd2) || (sel == 4'd15) || (sel == 4'd4);
            cyc(r, l, la, w, rd);
        end
        // R1 mid-run, then R7
        cyc(1'b1, 1'b0, 16'h0000, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
        summary();
        $finish;
    end

endmodule